// File: doc/BRIEF.md
# Dual-Field Register Datapath

This block is the execution core of a small processor whose instructions have no opcode of their own. Each 12-bit word pairs a destination-and-operation field (upper six bits) with a source field (lower six bits). Any destination field can be paired with any source field. In one clock cycle the block picks an operand from a register, an external input port or a constant table. It can add that operand to a register or subtract it from one, and it writes the result back.

The register file holds a 24-bit accumulator `a`, wide enough to sum 65536 eight-bit samples, and three 8-bit registers `b`, `c` and `d`. A single 24-bit adder/subtractor serves all four registers. For the 8-bit registers only the low byte of its result is kept. Instruction fetch and branching sit outside the block and deliver one instruction per cycle. The constant table and the external ports arrive as packed input vectors.

Top module: `dfx_datapath`

## Requirements
- R1: While `rst_n` is low, all four registers are cleared to zero asynchronously.
- R2: `instr[11:6]` is the destination field and `instr[5:0]` is the source field. Each field is decoded on its own and any pairing is legal.
- R3: Destination group `0000rr` loads register `rr` with the source value, truncated to 8 bits when `rr` is not 0, at the next clock edge.
- R4: Destination group `0001rr` adds the source value to register `rr`. The result wraps modulo 2^24 for `a` and modulo 2^8 for `b`/`c`/`d`.
- R5: Destination group `0010rr` subtracts the source value from register `rr`, with the same wrapping as R4.
- R6: The register code `rr` means 00=a, 01=b, 10=c, 11=d. At most one register write enable is active in a cycle, and registers that are not addressed keep their value.
- R7: Destination fields with a group other than 0000, 0001 or 0010 change no register.
- R8: Source `0000rr` selects register `rr`. `a` is given at its full 24 bits, and `b`/`c`/`d` are zero-extended.
- R9: Source `0001pp` selects external port `pp` (bits `ext_src[8pp+7:8pp]`), zero-extended.
- R10: Source `1kkkkk` selects constant entry `k` (bits `const_tbl[8k+7:8k]`), zero-extended. For example, `100111` selects entry 7.
- R11: Sources `0010xx` through `0111xx` give the value zero.
- R12: `src_bus` shows the selected source value combinationally, in the same cycle as the instruction.
- R13: When the source register is also the destination, the pre-edge value is read. For example, `a += a` doubles `a`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 12 | Destination field (11:6) and source field (5:0) |
| ext_src | input | 32 | Four 8-bit external source ports, packed |
| const_tbl | input | 256 | Thirty-two 8-bit constants, packed |
| a_q | output | 24 | Accumulator register |
| b_q | output | 8 | Register b |
| c_q | output | 8 | Register c |
| d_q | output | 8 | Register d |
| src_bus | output | 24 | Selected source operand |

## Verification
A register can be read as the source and written as the destination in the same cycle. If that happens, the read and the write-back overlap on one edge. The bench provokes this with `a += a`, `b += b` and `d -= d` patterns, and also through random pairings where the two register codes coincide. It judges the result against a behavioural model that takes the operand before updating its state. Wrap-around in both directions is driven as well: loading zero then subtracting one, and adding past the top. Each such case is compared against the model on the following cycle.

// File: rtl/dfx_pkg.sv
package dfx_pkg;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_NONE = 2'd3
  } dst_op_e;

  typedef enum logic [1:0] {
    SRC_REG   = 2'd0,
    SRC_EXT   = 2'd1,
    SRC_CONST = 2'd2,
    SRC_ZERO  = 2'd3
  } src_kind_e;

  localparam int FLD_W = 6;
  localparam int IDX_W = 5;

  // Operation group sits in the upper four bits of the destination field.
  function automatic dst_op_e decode_dst_op(input logic [FLD_W-1:0] f);
    case (f[5:2])
      4'b0000: return OP_LOAD;
      4'b0001: return OP_ADD;
      4'b0010: return OP_SUB;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic src_kind_e decode_src_kind(input logic [FLD_W-1:0] f);
    if (f[5])                  return SRC_CONST;
    else if (f[4:2] == 3'b000) return SRC_REG;
    else if (f[4:2] == 3'b001) return SRC_EXT;
    else                       return SRC_ZERO;
  endfunction

  function automatic logic [IDX_W-1:0] decode_src_idx(input logic [FLD_W-1:0] f);
    if (f[5]) return f[4:0];
    else      return {3'b000, f[1:0]};
  endfunction

endpackage

// File: rtl/dfx_decode.sv
module dfx_decode
  import dfx_pkg::*;
#(
  parameter int N_REG = 4
) (
  input  logic [FLD_W-1:0] dst_f,
  input  logic [FLD_W-1:0] src_f,
  output dst_op_e          op,
  output logic [1:0]       dst_sel,
  output logic [N_REG-1:0] we,
  output logic             sub_sel,
  output logic             load_sel,
  output src_kind_e        skind,
  output logic [IDX_W-1:0] sidx
);

  assign op       = decode_dst_op(dst_f);
  assign dst_sel  = dst_f[1:0];
  assign sub_sel  = (op == OP_SUB);
  assign load_sel = (op == OP_LOAD);
  assign skind    = decode_src_kind(src_f);
  assign sidx     = decode_src_idx(src_f);

  // One-hot clock enables from the two-bit register code.
  for (genvar i = 0; i < N_REG; i++) begin : g_we
    assign we[i] = (op != OP_NONE) && (dst_sel == 2'(i));
  end

endmodule

// File: rtl/dfx_srcmux.sv
module dfx_srcmux
  import dfx_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int REG_W   = 8,
  parameter int N_CONST = 32,
  parameter int N_EXT   = 4
) (
  input  src_kind_e              skind,
  input  logic [IDX_W-1:0]       sidx,
  input  logic [ACC_W-1:0]       a_val,
  input  logic [3*REG_W-1:0]     bcd_val,
  input  logic [N_EXT*REG_W-1:0] ext_src,
  input  logic [N_CONST*REG_W-1:0] const_tbl,
  output logic [ACC_W-1:0]       value
);

  localparam int N_REG = 4;

  logic [ACC_W-1:0] reg_arr [N_REG];
  logic [ACC_W-1:0] ext_arr [N_EXT];
  logic [ACC_W-1:0] cst_arr [N_CONST];

  assign reg_arr[0] = a_val;
  for (genvar i = 1; i < N_REG; i++) begin : g_reg
    assign reg_arr[i] = ACC_W'(bcd_val[(i-1)*REG_W +: REG_W]);
  end
  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    assign ext_arr[i] = ACC_W'(ext_src[i*REG_W +: REG_W]);
  end
  for (genvar i = 0; i < N_CONST; i++) begin : g_cst
    assign cst_arr[i] = ACC_W'(const_tbl[i*REG_W +: REG_W]);
  end

  logic [ACC_W-1:0] reg_pick, ext_pick, cst_pick;

  always_comb begin
    reg_pick = '0;
    for (int i = 0; i < N_REG; i++)
      if (sidx == IDX_W'(i)) reg_pick = reg_arr[i];
  end

  always_comb begin
    ext_pick = '0;
    for (int i = 0; i < N_EXT; i++)
      if (sidx == IDX_W'(i)) ext_pick = ext_arr[i];
  end

  always_comb begin
    cst_pick = '0;
    for (int i = 0; i < N_CONST; i++)
      if (sidx == IDX_W'(i)) cst_pick = cst_arr[i];
  end

  always_comb begin
    case (skind)
      SRC_REG:   value = reg_pick;
      SRC_EXT:   value = ext_pick;
      SRC_CONST: value = cst_pick;
      default:   value = '0;
    endcase
  end

endmodule

// File: rtl/dfx_alu.sv
module dfx_alu #(
  parameter int ACC_W = 24
) (
  input  logic [ACC_W-1:0] cur,
  input  logic [ACC_W-1:0] opnd,
  input  logic             sub_sel,
  input  logic             load_sel,
  output logic [ACC_W-1:0] result
);

  function automatic logic [ACC_W-1:0] addsub(
    input logic [ACC_W-1:0] x,
    input logic [ACC_W-1:0] y,
    input logic             sub
  );
    return sub ? (x - y) : (x + y);
  endfunction

  assign result = load_sel ? opnd : addsub(cur, opnd, sub_sel);

endmodule

// File: rtl/dfx_regfile.sv
module dfx_regfile #(
  parameter int ACC_W = 24,
  parameter int REG_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         we,
  input  logic [ACC_W-1:0]   wdata,
  output logic [ACC_W-1:0]   a_val,
  output logic [3*REG_W-1:0] bcd_val
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     a_val <= '0;
    else if (we[0]) a_val <= wdata;
  end

  for (genvar i = 1; i < 4; i++) begin : g_narrow
    logic [REG_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (we[i]) q <= wdata[REG_W-1:0];
    end
    assign bcd_val[(i-1)*REG_W +: REG_W] = q;
  end

endmodule

// File: rtl/dfx_datapath.sv
module dfx_datapath
  import dfx_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int REG_W   = 8,
  parameter int N_CONST = 32,
  parameter int N_EXT   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2*FLD_W-1:0]       instr,
  input  logic [N_EXT*REG_W-1:0]   ext_src,
  input  logic [N_CONST*REG_W-1:0] const_tbl,
  output logic [ACC_W-1:0]         a_q,
  output logic [REG_W-1:0]         b_q,
  output logic [REG_W-1:0]         c_q,
  output logic [REG_W-1:0]         d_q,
  output logic [ACC_W-1:0]         src_bus
);

  localparam int N_REG = 4;

  logic [FLD_W-1:0] dst_f, src_f;
  assign dst_f = instr[2*FLD_W-1:FLD_W];
  assign src_f = instr[FLD_W-1:0];

  dst_op_e          op;
  logic [1:0]       dst_sel;
  logic [N_REG-1:0] we_onehot;
  logic             sub_sel, load_sel;
  src_kind_e        skind;
  logic [IDX_W-1:0] sidx;

  dfx_decode #(.N_REG(N_REG)) u_dec (
    .dst_f    (dst_f),
    .src_f    (src_f),
    .op       (op),
    .dst_sel  (dst_sel),
    .we       (we_onehot),
    .sub_sel  (sub_sel),
    .load_sel (load_sel),
    .skind    (skind),
    .sidx     (sidx)
  );

  logic [ACC_W-1:0]   a_val;
  logic [3*REG_W-1:0] bcd_val;
  logic [ACC_W-1:0]   src_val;

  dfx_srcmux #(
    .ACC_W(ACC_W), .REG_W(REG_W), .N_CONST(N_CONST), .N_EXT(N_EXT)
  ) u_mux (
    .skind     (skind),
    .sidx      (sidx),
    .a_val     (a_val),
    .bcd_val   (bcd_val),
    .ext_src   (ext_src),
    .const_tbl (const_tbl),
    .value     (src_val)
  );

  // Current value of the addressed destination, zero-extended.
  logic [ACC_W-1:0] dst_cur;
  always_comb begin
    case (dst_sel)
      2'd0:    dst_cur = a_val;
      2'd1:    dst_cur = ACC_W'(bcd_val[0*REG_W +: REG_W]);
      2'd2:    dst_cur = ACC_W'(bcd_val[1*REG_W +: REG_W]);
      default: dst_cur = ACC_W'(bcd_val[2*REG_W +: REG_W]);
    endcase
  end

  logic [ACC_W-1:0] wb_val;

  dfx_alu #(.ACC_W(ACC_W)) u_alu (
    .cur      (dst_cur),
    .opnd     (src_val),
    .sub_sel  (sub_sel),
    .load_sel (load_sel),
    .result   (wb_val)
  );

  dfx_regfile #(.ACC_W(ACC_W), .REG_W(REG_W)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we_onehot),
    .wdata   (wb_val),
    .a_val   (a_val),
    .bcd_val (bcd_val)
  );

  assign a_q     = a_val;
  assign b_q     = bcd_val[0*REG_W +: REG_W];
  assign c_q     = bcd_val[1*REG_W +: REG_W];
  assign d_q     = bcd_val[2*REG_W +: REG_W];
  assign src_bus = src_val;

endmodule

// File: rtl/dfx_datapath_chk.sv
module dfx_datapath_chk #(
  parameter int ACC_W = 24,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       dst_f,
  input logic [3:0]       we,
  input logic [ACC_W-1:0] a_q,
  input logic [REG_W-1:0] b_q,
  input logic [REG_W-1:0] c_q,
  input logic [REG_W-1:0] d_q,
  input logic [ACC_W-1:0] src_bus
);

  logic op_valid;
  assign op_valid = (dst_f[5:4] == 2'b00) && (dst_f[3:2] != 2'b11);

  p_onehot_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(we));

  p_we_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (we != 4'b0000));

  p_nop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(a_q) && $stable(b_q) && $stable(c_q) && $stable(d_q)));

  p_load_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_f == 6'b000010) |=> (c_q == $past(src_bus[REG_W-1:0])));

  p_add_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_f == 6'b000100) |=> (a_q == ACC_W'($past(a_q) + $past(src_bus))));

  p_sub_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_f == 6'b001001) |=> (b_q == REG_W'($past(b_q) - $past(src_bus[REG_W-1:0]))));

endmodule

bind dfx_datapath dfx_datapath_chk #(.ACC_W(ACC_W), .REG_W(REG_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dst_f   (dst_f),
  .we      (we_onehot),
  .a_q     (a_q),
  .b_q     (b_q),
  .c_q     (c_q),
  .d_q     (d_q),
  .src_bus (src_bus)
);

// File: tb/dfx_datapath_tb_top.sv
module dfx_datapath_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  instr = 12'h000;
  logic [31:0]  ext_src = '0;
  logic [255:0] const_tbl = '0;
  logic [23:0]  a_q, src_bus;
  logic [7:0]   b_q, c_q, d_q;

  always #2 clk = ~clk;

  dfx_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .ext_src(ext_src),
    .const_tbl(const_tbl), .a_q(a_q), .b_q(b_q), .c_q(c_q), .d_q(d_q),
    .src_bus(src_bus)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model state.
  int mreg [4];
  int ctab [32];
  int extv [4];
  logic [31:0] lf = 32'h1234_5678;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mask_of(input int r);
    return (r == 0) ? 32'h00FF_FFFF : 32'h0000_00FF;
  endfunction

  function automatic int model_src(input logic [5:0] s);
    if (s[5])               return ctab[s[4:0]];
    if (s[4:2] == 3'b000)   return mreg[s[1:0]];
    if (s[4:2] == 3'b001)   return extv[s[1:0]];
    return 0;
  endfunction

  function automatic string src_tag(input logic [5:0] s);
    if (s[5])             return "R10/R12";
    if (s[4:2] == 3'b000) return "R8/R12";
    if (s[4:2] == 3'b001) return "R9/R12";
    return "R11/R12";
  endfunction

  task automatic push_inputs();
    for (int k = 0; k < 32; k++) const_tbl[k*8 +: 8] = 8'(ctab[k]);
    for (int k = 0; k < 4; k++)  ext_src[k*8 +: 8]   = 8'(extv[k]);
  endtask

  // Called just after a falling edge: drive, check source, step, compare.
  task automatic run(input logic [11:0] ins, input string note);
    int v, g, r;
    int nxt [4];
    string dtag;
    instr = ins;
    push_inputs();
    #1;
    v = model_src(ins[5:0]);
    chk({src_tag(ins[5:0]), note}, int'(src_bus), v);
    g = int'(ins[11:8]);
    r = int'(ins[7:6]);
    for (int k = 0; k < 4; k++) nxt[k] = mreg[k];
    case (g)
      0: begin nxt[r] = v & mask_of(r);            dtag = "R3"; end
      1: begin nxt[r] = (mreg[r] + v) & mask_of(r); dtag = "R4"; end
      2: begin nxt[r] = (mreg[r] - v) & mask_of(r); dtag = "R5"; end
      default: dtag = "R7";
    endcase
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 4; k++) mreg[k] = nxt[k];
    chk({(g < 3) ? dtag : "R7", note, " a"}, int'(a_q), mreg[0]);
    chk({(g < 3 && r == 1) ? dtag : "R6", note, " b"}, int'(b_q), mreg[1]);
    chk({(g < 3 && r == 2) ? dtag : "R6", note, " c"}, int'(c_q), mreg[2]);
    chk({(g < 3 && r == 3) ? dtag : "R6", note, " d"}, int'(d_q), mreg[3]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 32; k++) ctab[k] = (k * 29 + 5) & 255;
    extv[0] = 8'hC3; extv[1] = 8'h5A; extv[2] = 8'hFF; extv[3] = 8'h01;
    for (int k = 0; k < 4; k++) mreg[k] = 0;
    push_inputs();
    instr = 12'b000000_000000;
    repeat (3) @(negedge clk);
    // R1: reset state, with a's stale source reading zero
    chk("R1 a", int'(a_q), 0);
    chk("R1 b", int'(b_q), 0);
    chk("R1 c", int'(c_q), 0);
    chk("R1 d", int'(d_q), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(12'b000000_100111, " load a const7");
    run(12'b000100_100111, " a+=const7");
    run(12'b000001_000100, " b=ext0");
    run(12'b000010_000000, " c=a low byte");
    run(12'b001011_100011, " d-=const3 wrap");
    run(12'b000111_000001, " R2 d+=b");
    run(12'b000000_001000, " R11 a=zero");
    run(12'b001000_000111, " a-=ext3 wrap");
    run(12'b000100_000111, " a+=ext3 wrap up");
    run(12'b000000_100111, " reload a");
    run(12'b000100_000000, " R13 a+=a");
    run(12'b000100_000000, " R13 a+=a again");
    run(12'b000101_000001, " R13 b+=b");
    run(12'b001011_000011, " R13 d-=d");
    run(12'b000011_000110, " d=ext2");
    run(12'b001111_100111, " R7 group 0011");
    run(12'b111111_000000, " R7 group 1111");
    run(12'b100111_000100, " R2 swapped fields");
    run(12'b010001_111111, " R7 group 0100");
    run(12'b000001_011100, " R11 b=zero code");
    run(12'b000010_111111, " R10 c=const31");

    for (int n = 0; n < 600; n++) begin
      logic [11:0] ins;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      ins = lf[11:0];
      if (lf[20:18] != 3'b000) ins[11:10] = 2'b00;
      if (lf[25:23] == 3'b000) begin
        ctab[lf[4:0]] = int'(lf[31:24]);
        extv[lf[6:5]] = int'(lf[15:8]);
      end
      run(ins, " random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule